// File: doc/BRIEF.md
# Timed Page Commit Engine for a Serial Byte-Addressed Memory

This block sits between the two-wire bus protocol engine of a small serial memory and its byte array. While a write transaction is in progress, the protocol engine hands over each received data byte together with its offset inside the page. The block keeps those bytes in a page buffer and marks each offset it has received. Nothing reaches the array until the transaction closes with a stop condition.

At the stop, the block begins an internal write cycle of fixed length. It raises `busy` for the whole cycle, and the protocol engine uses that signal to refuse the device address, which is how acknowledge polling works. In the first cycles of that window, the block sends every marked byte to the array, one per clock, in ascending offset order. A write-protect input, sampled when the stop arrives, blocks every write to the upper half of the array. A transaction that ends in a repeated start, such as the address phase of a random read, leaves the array untouched.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy` and `arr_we` are both low.
- R2: A byte strobed at offset k, with `page_base` selecting page row r, is written to array address {r, k} with the strobed data. The row is the upper ADDR_W-log2(PAGE_BYTES) bits of `page_base`.
- R3: Only the offsets received since the last start are written, one per clock, in ascending offset order. The first write comes in the cycle after the stop is sampled, and all writes complete within the first PAGE_BYTES cycles of the busy window.
- R4: When an offset is strobed more than once, as happens when more than a page of data wraps around, only the last value for that offset is written, and it is written once.
- R5: A stop sampled while the buffer holds at least one byte sets `busy` in the next cycle. `busy` then stays high for exactly WR_CYCLES cycles.
- R6: A stop sampled while no byte is buffered starts no write cycle and produces no array write.
- R7: A start condition discards every buffered byte, so a start followed by a stop writes nothing.
- R8: While `busy` is high, byte strobes, starts and stops have no effect. The bytes being committed are unchanged, and a stop after the cycle ends starts no new cycle.
- R9: With `wp` high when the stop is sampled, no write is issued to any address whose most significant bit is 1. Buffered bytes for the lower half are written normally, and the timed cycle still runs.
- R10: With `wp` low when the stop is sampled, writes to the upper half of the array are issued normally.
- R11: `arr_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse at each start or repeated start condition |
| byte_we | input | 1 | One-cycle strobe: a data byte was received |
| byte_off | input | log2(PAGE_BYTES) | In-page offset of the strobed byte |
| byte_data | input | 8 | Received data byte |
| page_base | input | ADDR_W | Word address of the transaction; its upper bits select the page row |
| xfer_stop | input | 1 | One-cycle pulse at a stop condition |
| wp | input | 1 | Write protect for the upper half of the array, sampled at the stop |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume the following about the inputs. Each event arrives as a single-cycle pulse. A byte strobe never falls in the same cycle as the stop that closes its transaction. `page_base` holds one row for the whole transaction. WR_CYCLES is at least PAGE_BYTES. The stimulus drives each pulse one cycle after a clock edge and separates the last byte from the stop by at least one cycle. It keeps one row per transaction and runs the default parameters, where the busy window is longer than the page. Within those limits, the checks cover row stability and ascending offsets inside each burst of array writes, the exact busy length, and the absence of any upper-half write while protection was sampled high.

// File: rtl/pwc_pkg.sv
// Shared types and helpers for the timed page commit engine.
// Assumes byte-wide array data.
package pwc_pkg;

    typedef logic [7:0] data_t;

    // True when the write-protect latch forbids the target half of the array.
    function automatic logic upper_blocked(input logic wp_q, input logic addr_msb);
        return wp_q && addr_msb;
    endfunction

endpackage

// File: rtl/pwc_page_buf.sv
// Page buffer with one valid flag per offset.
// Stores received bytes while accept is high, discards everything on a start
// condition or at the end of a commit, and serves one offset for the commit scan.
// Assumes a start and a byte strobe never arrive in the same cycle (start wins if they do).
module pwc_page_buf
    import pwc_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int ROW_W      = 5,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             discard,
    input  logic             drop,
    input  logic             byte_we,
    input  logic [OFF_W-1:0] byte_off,
    input  data_t            byte_data,
    input  logic [ROW_W-1:0] row_in,
    input  logic [OFF_W-1:0] rd_idx,
    output data_t            rd_data,
    output logic             rd_valid,
    output logic             any_valid,
    output logic [ROW_W-1:0] row_q
);

    data_t                 data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Capture one offset's byte and mark it pending.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                data_q[g] <= '0;
            end else if ((accept && discard) || drop) begin
                vld_q[g]  <= 1'b0;
            end else if (accept && byte_we && (byte_off == OFF_W'(g))) begin
                vld_q[g]  <= 1'b1;
                data_q[g] <= byte_data;
            end
        end
    end

    // Track the page row of the transaction in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (accept && byte_we) begin
            row_q <= row_in;
        end
    end

    // Read port for the commit scan.
    always_comb begin
        rd_data   = data_q[rd_idx];
        rd_valid  = vld_q[rd_idx];
        any_valid = |vld_q;
    end

endmodule

// File: rtl/pwc_cycle_timer.sv
// Fixed-length internal write cycle timer.
// busy rises the cycle after launch and stays high for exactly WR_CYCLES cycles.
// elapsed counts from zero in the first busy cycle. done marks the last busy cycle.
// Assumes launch is only asserted while busy is low.
module pwc_cycle_timer #(
    parameter int WR_CYCLES = 40,
    localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    output logic             busy,
    output logic [CNT_W-1:0] elapsed,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

    // Run the busy window and its cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            elapsed <= '0;
        end else if (launch && !busy) begin
            busy    <= 1'b1;
            elapsed <= '0;
        end else if (busy) begin
            if (elapsed == LAST) begin
                busy <= 1'b0;
            end else begin
                elapsed <= elapsed + 1'b1;
            end
        end
    end

    // Flag the final cycle of the window.
    always_comb begin
        done = busy && (elapsed == LAST);
    end

endmodule

// File: rtl/pwc_commit.sv
// Commit stage: walks the offsets in the first PAGE_BYTES busy cycles and
// drives one array write per pending offset. Writes to the upper half are
// masked when write protect was high at launch.
// Assumes WR_CYCLES >= PAGE_BYTES, so the scan always completes.
module pwc_commit
    import pwc_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    parameter int CNT_W      = 6,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int ROW_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              wp,
    input  logic              busy,
    input  logic [CNT_W-1:0]  elapsed,
    input  logic              rd_valid,
    input  data_t             rd_data,
    input  logic [ROW_W-1:0]  row,
    output logic [OFF_W-1:0]  scan_idx,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output data_t             arr_wdata
);

    logic wp_q;
    logic scanning;

    // Sample write protect when the cycle is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= 1'b0;
        end else if (launch && !busy) begin
            wp_q <= wp;
        end
    end

    // Form the array write for the offset under scan.
    always_comb begin
        scanning  = busy && (32'(elapsed) < PAGE_BYTES);
        scan_idx  = elapsed[OFF_W-1:0];
        arr_addr  = {row, scan_idx};
        arr_wdata = rd_data;
        arr_we    = scanning && rd_valid && !upper_blocked(wp_q, row[ROW_W-1]);
    end

endmodule

// File: rtl/page_write_ctrl.sv
// Timed page commit engine: buffers the bytes of a write transaction and
// commits them after the closing stop, inside a fixed busy window.
// Assumes single-cycle event pulses, a constant page row per transaction,
// no byte strobe in the same cycle as the stop, and WR_CYCLES >= PAGE_BYTES.
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 40,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int ROW_W     = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              byte_we,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [7:0]        byte_data,
    input  logic [ADDR_W-1:0] page_base,
    input  logic              xfer_stop,
    input  logic              wp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              busy
);

    logic             launch;
    logic             done;
    logic             any_valid;
    logic             rd_valid;
    data_t            rd_data;
    logic [ROW_W-1:0] row_q;
    logic [OFF_W-1:0] scan_idx;
    logic [CNT_W-1:0] elapsed;

    // A stop with buffered data opens the write cycle.
    always_comb begin
        launch = xfer_stop && !busy && any_valid;
    end

    pwc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (!busy),
        .discard   (xfer_start),
        .drop      (done),
        .byte_we   (byte_we),
        .byte_off  (byte_off),
        .byte_data (byte_data),
        .row_in    (page_base[ADDR_W-1:OFF_W]),
        .rd_idx    (scan_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid),
        .row_q     (row_q)
    );

    pwc_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .busy    (busy),
        .elapsed (elapsed),
        .done    (done)
    );

    pwc_commit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .wp        (wp),
        .busy      (busy),
        .elapsed   (elapsed),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .row       (row_q),
        .scan_idx  (scan_idx),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

endmodule

// File: rtl/pwc_checker.sv
// Temporal checks for page_write_ctrl, attached with bind.
// Assumes the input conditions listed in the block's brief.
module pwc_checker #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 40,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_stop,
    input logic              wp,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              busy
);

    int unsigned run_len;
    logic        wp_seen;

    // Count the length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // Remember write protect as seen at the last accepted stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wp_seen <= 1'b0;
        else if (xfer_stop && !busy) wp_seen <= wp;
    end

    p_we_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(xfer_stop));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == WR_CYCLES));

    p_wp_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !(wp_seen && arr_addr[ADDR_W-1]));

    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])) &&
            (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])));

endmodule

bind page_write_ctrl pwc_checker #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_pwc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_stop (xfer_stop),
    .wp        (wp),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .busy      (busy)
);

// File: tb/test_page_write_ctrl.sv
module test_page_write_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 9;
    localparam int PAGE_BYTES = 16;
    localparam int WR_CYCLES  = 40;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int ROW_W      = ADDR_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_start = 1'b0;
    logic              byte_we = 1'b0;
    logic [OFF_W-1:0]  byte_off = '0;
    logic [7:0]        byte_data = '0;
    logic [ADDR_W-1:0] page_base = '0;
    logic              xfer_stop = 1'b0;
    logic              wp = 1'b0;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;
    logic              busy;

    int checks = 0;
    int errors = 0;
    int busy_run = 0;
    logic [ADDR_W+7:0] exp_q [$];

    logic [7:0]            m_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] m_vld = '0;
    int                    m_row = 0;
    logic                  m_busy = 1'b0;

    page_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) i_page_write_ctrl (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .byte_we(byte_we),
        .byte_off(byte_off), .byte_data(byte_data), .page_base(page_base),
        .xfer_stop(xfer_stop), .wp(wp), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: one byte strobe, updating the model unless the design is busy.
    task automatic put_byte(input int row, input int off, input logic [7:0] d);
        page_base = ADDR_W'((row << OFF_W) | off);
        byte_off  = OFF_W'(off);
        byte_data = d;
        byte_we   = 1'b1;
        tick();
        byte_we   = 1'b0;
        if (!m_busy) begin
            m_data[off] = d;
            m_vld[off]  = 1'b1;
            m_row       = row;
        end
    endtask

    task automatic send_start();
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
        if (!m_busy) m_vld = '0;
    endtask

    // Driver: stop; pushes the expected commits in ascending offset order.
    task automatic send_stop();
        logic launch;
        launch = !m_busy && (m_vld != '0);
        xfer_stop = 1'b1;
        tick();
        xfer_stop = 1'b0;
        if (launch) begin
            for (int k = 0; k < PAGE_BYTES; k++) begin
                if (m_vld[k] && !(wp && (m_row >= (1 << (ROW_W-1)))))
                    exp_q.push_back({ADDR_W'((m_row << OFF_W) | k), m_data[k]});
            end
            m_vld  = '0;
            m_busy = 1'b1;
            check(busy == 1'b1, "R5 busy after stop", busy, 1);
        end else if (!m_busy) begin
            check(busy == 1'b0, "R6/R7 no cycle on empty stop", busy, 0);
        end
    endtask

    // Wait for the window to close, then check its length and the scoreboard.
    task automatic finish_cycle(input string tag);
        while (busy) tick();
        m_busy = 1'b0;
        check(busy_run == WR_CYCLES, "R5 busy length", busy_run, WR_CYCLES);
        busy_run = 0;
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor: pops expected writes and counts busy cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_run++;
            if (arr_we) begin
                if (!busy) begin
                    check(1'b0, "R11 write outside busy", arr_addr, 0);
                end else if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected array write", {arr_addr, arr_wdata}, 0);
                end else begin
                    logic [ADDR_W+7:0] e;
                    e = exp_q.pop_front();
                    check({arr_addr, arr_wdata} == e, "R2 write addr/data", {arr_addr, arr_wdata}, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(arr_we == 1'b0, "R1 arr_we after reset", arr_we, 0);
        rst_n = 1'b1;
        tick();

        // R2: full page to row 3
        send_start();
        for (int k = 0; k < PAGE_BYTES; k++) put_byte(3, k, 8'(8'hA0 + k));
        tick();
        send_stop();
        finish_cycle("R2 full page committed");

        // R3: partial page, out of order
        send_start();
        put_byte(7, 9, 8'h19);
        put_byte(7, 2, 8'h12);
        put_byte(7, 5, 8'h15);
        tick();
        send_stop();
        finish_cycle("R3 partial page committed");

        // R4: more than a page wraps, last value wins
        send_start();
        for (int k = 0; k < PAGE_BYTES; k++) put_byte(4, k, 8'(k));
        put_byte(4, 0, 8'hE0);
        put_byte(4, 1, 8'hE1);
        tick();
        send_stop();
        finish_cycle("R4 wrap overwrites");

        // R6: stop with nothing buffered
        send_start();
        tick();
        send_stop();
        tick();
        check(busy == 1'b0, "R6 still idle", busy, 0);

        // R7: repeated start discards buffered bytes
        send_start();
        put_byte(6, 3, 8'h33);
        send_start();
        send_stop();
        tick();
        check(busy == 1'b0, "R7 nothing launched", busy, 0);

        // R8: inputs ignored during busy
        send_start();
        put_byte(2, 1, 8'h21);
        tick();
        send_stop();
        put_byte(2, 3, 8'h23);
        send_start();
        send_stop();
        finish_cycle("R8 only pre-stop byte committed");
        send_stop();
        tick();
        check(busy == 1'b0, "R8 no cycle from ignored byte", busy, 0);

        // R9: protected upper half, cycle still runs
        wp = 1'b1;
        send_start();
        put_byte(20, 0, 8'h50);
        put_byte(20, 1, 8'h51);
        tick();
        send_stop();
        finish_cycle("R9 upper half blocked");

        // R9: protected mode still writes the lower half
        send_start();
        put_byte(5, 7, 8'h57);
        tick();
        send_stop();
        finish_cycle("R9 lower half written");

        // R10: unprotected upper half
        wp = 1'b0;
        send_start();
        put_byte(31, 15, 8'hFF);
        put_byte(31, 0, 8'hF0);
        tick();
        send_stop();
        finish_cycle("R10 upper half written");

        repeat (3) tick();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule